// File: doc/BRIEF.md
# Four-Bank Interleaved Memory Sequencer

The sequencer sits between a single request stream and four independent memory banks. Each bank has a cycle time that is longer than a single issue slot. The two low bits of each word address select a bank. The remaining bits travel to that bank as the in-bank address. Each bank therefore serves every fourth word. A run of consecutive addresses can start a new bank access on every clock while the earlier banks are still finishing their cycles.

A per-bank countdown blocks a bank for `CYCLE_T` clocks after it starts. The request channel's `req_ready` drops only while the addressed bank is inside that window, or when a read arrives and the response store is full. When every request targets the same bank, requests are accepted once per bank cycle, exactly as in a memory without interleaving.

Reads reserve a slot in an in-order response store at issue. Each slot is filled when the bank signals completion, and slots drain on a valid/ready response channel in request order. Writes follow the same bank availability rule but produce no response.

Top module: `interleave_seq`

## Requirements
- R1: An accepted request raises exactly one bit of `bank_start` for one cycle, in the clock after acceptance. The bit index is `req_addr[1:0]`. In the same cycle, `bank_addr` carries `req_addr[ADDR_W-1:2]`, and `bank_we`/`bank_wdata` carry the request's write flag and data.
- R2: Once a bank has been started, it is not started again for `CYCLE_T` clocks. Back-to-back requests to one bank are accepted exactly `CYCLE_T` clocks apart.
- R3: Requests to different idle banks are accepted on consecutive clocks. For consecutive word addresses, banks 0 to 3 start on four successive clocks, and bank 0 is accepted again as soon as its own window has expired.
- R4: While the addressed bank is within its window, `req_ready` is low and no `bank_start` bit is raised.
- R5: Read data, taken from the bank's `bank_rdata` slice in the cycle its `bank_done` bit is high, leaves on `rsp_valid`/`rsp_data` in the order the reads were accepted.
- R6: An accepted write never produces a response beat.
- R7: While `QD` reads are awaiting delivery, a further read is held off with `req_ready` low. A write to an idle bank is still accepted.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and `rsp_data` holds its value.
- R9: During and right after reset, `req_ready` is high, `bank_start` is zero and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address; bits [1:0] pick the bank |
| req_wdata | input | DATA_W | Write data |
| bank_start | output | 4 | One-cycle start strobe, one bit per bank |
| bank_we | output | 1 | Write flag for the started access |
| bank_addr | output | ADDR_W-2 | In-bank word address |
| bank_wdata | output | DATA_W | Write data for the started access |
| bank_done | input | 4 | Per-bank completion strobe |
| bank_rdata | input | 4*DATA_W | Per-bank read data, bank n at bits [n*DATA_W +: DATA_W] |
| rsp_valid | output | 1 | Read response present |
| rsp_data | output | DATA_W | Read response data |
| rsp_ready | input | 1 | Response taken this cycle when valid |

## Verification
The bench builds the sequencer with a 6-bit address, 16-bit data, a response store of eight entries and a bank cycle of five clocks, and drives a bank model with a three-clock access latency. A cycle of five, one longer than the bank count, makes a sequential stream stall for one clock whenever it wraps back to bank 0. This separates the interleaved timing from the same-bank timing. The 6-bit address lets the topmost word and in-bank address be exercised. Eight entries are few enough that holding `rsp_ready` low fills the store, so the read stall and the write bypass can both be observed.

// File: rtl/interleave_pkg.sv
package interleave_pkg;
  localparam int NUM_BANKS = 4;
  localparam int BANK_W    = 2;
  typedef logic [BANK_W-1:0] bank_idx_t;
endpackage

// File: rtl/interleave_bank_timer.sv
module interleave_bank_timer #(
  parameter int CYCLE_T = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int TMR_W = (CYCLE_T > 1) ? $clog2(CYCLE_T) : 1;

  logic [TMR_W-1:0] cnt;

  // Loading CYCLE_T-1 lets the bank be re-accepted exactly CYCLE_T clocks later.
  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (start)       cnt <= TMR_W'(CYCLE_T - 1);
    else if (cnt != '0)   cnt <= cnt - TMR_W'(1);
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/interleave_rsp_queue.sv
module interleave_rsp_queue #(
  parameter int DATA_W = 32,
  parameter int QD     = 8,
  parameter int NB     = 4,
  localparam int PTR_W = $clog2(QD)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 alloc,
  output logic [PTR_W-1:0]     alloc_slot,
  output logic                 full,
  input  logic [NB-1:0]        fill,
  input  logic [NB*PTR_W-1:0]  fill_slot,
  input  logic [NB*DATA_W-1:0] fill_data,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_data,
  input  logic                 rsp_ready
);
  localparam int CNT_W = $clog2(QD + 1);

  logic [DATA_W-1:0] store [QD];
  logic [QD-1:0]     filled;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  used;
  logic              pop;

  assign pop        = rsp_valid && rsp_ready;
  assign alloc_slot = wr_ptr;
  assign full       = (used == CNT_W'(QD));
  assign rsp_valid  = filled[rd_ptr];
  assign rsp_data   = store[rd_ptr];

  // Data store: no reset, plain indexed writes.
  always_ff @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (fill[b]) store[fill_slot[b*PTR_W +: PTR_W]] <= fill_data[b*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      filled <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      used   <= '0;
    end else begin
      if (pop) begin
        filled[rd_ptr] <= 1'b0;
        rd_ptr         <= rd_ptr + PTR_W'(1);
      end
      for (int b = 0; b < NB; b++) begin
        if (fill[b]) filled[fill_slot[b*PTR_W +: PTR_W]] <= 1'b1;
      end
      if (alloc) wr_ptr <= wr_ptr + PTR_W'(1);
      case ({alloc, pop})
        2'b10:   used <= used + CNT_W'(1);
        2'b01:   used <= used - CNT_W'(1);
        default: used <= used;
      endcase
    end
  end
endmodule

// File: rtl/interleave_seq.sv
module interleave_seq
  import interleave_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int CYCLE_T = 4,
  parameter int QD      = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_we,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [DATA_W-1:0]           req_wdata,
  output logic [3:0]                  bank_start,
  output logic                        bank_we,
  output logic [ADDR_W-3:0]           bank_addr,
  output logic [DATA_W-1:0]           bank_wdata,
  input  logic [3:0]                  bank_done,
  input  logic [4*DATA_W-1:0]         bank_rdata,
  output logic                        rsp_valid,
  output logic [DATA_W-1:0]           rsp_data,
  input  logic                        rsp_ready
);
  localparam int PTR_W = $clog2(QD);
  localparam int SUB_W = ADDR_W - BANK_W;

  bank_idx_t                  tgt;
  logic [NUM_BANKS-1:0]       busy, fire_vec, fill;
  logic [NUM_BANKS*PTR_W-1:0] slot_flat;
  logic [PTR_W-1:0]           alloc_slot;
  logic                       q_full, fire, rd_fire;

  assign tgt       = req_addr[BANK_W-1:0];
  assign req_ready = !busy[tgt] && (req_we || !q_full);
  assign fire      = req_valid && req_ready;
  assign rd_fire   = fire && !req_we;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             pend_r;
    logic [PTR_W-1:0] slot_r;

    assign fire_vec[b] = fire && (tgt == BANK_W'(b));

    interleave_bank_timer #(.CYCLE_T(CYCLE_T)) u_tmr (
      .clk   (clk),
      .rst   (rst),
      .start (fire_vec[b]),
      .busy  (busy[b])
    );

    // Remember which response slot this bank's outstanding read owns.
    always_ff @(posedge clk) begin
      if (rst)               pend_r <= 1'b0;
      else if (fire_vec[b])  pend_r <= !req_we;
      else if (bank_done[b]) pend_r <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (fire_vec[b] && !req_we) slot_r <= alloc_slot;
    end

    assign fill[b]                       = bank_done[b] && pend_r;
    assign slot_flat[b*PTR_W +: PTR_W]   = slot_r;
  end

  // Registered bank command.
  always_ff @(posedge clk) begin
    if (rst) bank_start <= '0;
    else     bank_start <= fire_vec;
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      bank_we    <= req_we;
      bank_addr  <= req_addr[ADDR_W-1:BANK_W];
      bank_wdata <= req_wdata;
    end
  end

  interleave_rsp_queue #(.DATA_W(DATA_W), .QD(QD), .NB(NUM_BANKS)) u_q (
    .clk        (clk),
    .rst        (rst),
    .alloc      (rd_fire),
    .alloc_slot (alloc_slot),
    .full       (q_full),
    .fill       (fill),
    .fill_slot  (slot_flat),
    .fill_data  (bank_rdata),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .rsp_ready  (rsp_ready)
  );

  logic [SUB_W-1:0] unused_sub;
  assign unused_sub = req_addr[ADDR_W-1:BANK_W];
endmodule

// File: rtl/interleave_seq_chk.sv
module interleave_seq_chk #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int CYCLE_T = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [3:0]        bank_start,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data
);
  localparam int CW = $clog2(CYCLE_T + 1);

  assert_onehot_start_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_start));

  assert_start_bank_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (bank_start == (4'b0001 << $past(req_addr[1:0]))));

  assert_idle_no_start_R4: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> (bank_start == 4'b0000));

  assert_hold_rsp_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R2: count clocks since each bank's last start.
  for (genvar b = 0; b < 4; b++) begin : g_gap
    logic [CW-1:0] since;
    always_ff @(posedge clk) begin
      if (rst)                          since <= CW'(CYCLE_T);
      else if (bank_start[b])           since <= CW'(1);
      else if (since < CW'(CYCLE_T))    since <= since + CW'(1);
    end
    assert_bank_gap_R2: assert property (@(posedge clk) disable iff (rst)
      bank_start[b] |-> (since >= CW'(CYCLE_T)));
  end
endmodule

bind interleave_seq interleave_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CYCLE_T(CYCLE_T)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .bank_start(bank_start), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_data(rsp_data)
);

// File: tb/interleave_seq_bench.sv
`timescale 1ns/1ps
module interleave_seq_bench;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int CT = 5;
  localparam int QDEPTH = 8;
  localparam int ACC_LAT = 3;

  logic clk = 1'b0;
  logic rst;
  logic req_valid, req_ready, req_we;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [3:0] bank_start, bank_done;
  logic bank_we;
  logic [AW-3:0] bank_addr;
  logic [DW-1:0] bank_wdata;
  logic [4*DW-1:0] bank_rdata;
  logic rsp_valid, rsp_ready;
  logic [DW-1:0] rsp_data;

  always #4 clk = ~clk;

  interleave_seq #(.ADDR_W(AW), .DATA_W(DW), .CYCLE_T(CT), .QD(QDEPTH)) u_interleave_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .bank_start(bank_start), .bank_we(bank_we),
    .bank_addr(bank_addr), .bank_wdata(bank_wdata), .bank_done(bank_done),
    .bank_rdata(bank_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ready(rsp_ready)
  );

  int nchk = 0;
  int nerr = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] init_val(input int a);
    return DW'(a * 7 + 3) ^ 16'h5A00;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bank model: fixed access latency, storage indexed by full word address.
  logic [DW-1:0] bmem [64];
  int lcnt [4];
  logic [AW-3:0] laddr [4];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) bmem[i] <= init_val(i);
      for (int b = 0; b < 4; b++) lcnt[b] <= 0;
    end else begin
      for (int b = 0; b < 4; b++) begin
        if (bank_start[b]) begin
          if (bank_we) bmem[{bank_addr, 2'(b)}] <= bank_wdata;
          lcnt[b]  <= ACC_LAT;
          laddr[b] <= bank_addr;
        end else if (lcnt[b] != 0) begin
          lcnt[b] <= lcnt[b] - 1;
        end
      end
    end
  end

  always_comb begin
    for (int b = 0; b < 4; b++) begin
      bank_done[b] = (lcnt[b] == 1);
      bank_rdata[b*DW +: DW] = bmem[{laddr[b], 2'(b)}];
    end
  end

  // Expectations built from the requirements.
  logic [DW-1:0] shadow [64];
  logic [DW-1:0] exp_q [$];
  int            st_cyc_q [$];
  logic [AW-1:0] st_addr_q [$];
  logic          st_we_q [$];

  always @(negedge clk) begin
    if (!rst) begin
      if (bank_start != 4'b0) begin
        if (st_cyc_q.size() == 0) begin
          chk(1'b0, "R1 unexpected start", int'(bank_start), 0);
        end else begin
          int pc;
          logic [AW-1:0] pa;
          logic pw;
          pc = st_cyc_q.pop_front();
          pa = st_addr_q.pop_front();
          pw = st_we_q.pop_front();
          chk(bank_start == (4'b0001 << pa[1:0]) && bank_addr == pa[AW-1:2] &&
              bank_we == pw && cyc == pc + 1, "R1 start command",
              int'({bank_start, bank_we, bank_addr}), int'({4'b0001 << pa[1:0], pw, pa[AW-1:2]}));
        end
      end
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected response", int'(rsp_data), 0);
        end else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk(rsp_data == e, "R5 response order/data", int'(rsp_data), int'(e));
        end
      end
    end
  end

  task automatic issue(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d, output int fc);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1;
    end
    fc = cyc;
    st_cyc_q.push_back(cyc);
    st_addr_q.push_back(a);
    st_we_q.push_back(we);
    if (we) shadow[a] = d;
    else    exp_q.push_back(shadow[a]);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // {we, addr, wdata, expected clocks since previous acceptance (0 = unchecked)}
  localparam logic [26:0] VEC [24] = '{
    {1'b1, 6'd0,  16'hA000, 4'd0}, {1'b1, 6'd1,  16'hA001, 4'd1},
    {1'b1, 6'd2,  16'hA002, 4'd1}, {1'b1, 6'd3,  16'hA003, 4'd1},
    {1'b1, 6'd4,  16'hA004, 4'd2}, {1'b1, 6'd5,  16'hA005, 4'd1},
    {1'b1, 6'd6,  16'hA006, 4'd1}, {1'b1, 6'd7,  16'hA007, 4'd1},
    {1'b0, 6'd0,  16'h0000, 4'd2}, {1'b0, 6'd1,  16'h0000, 4'd1},
    {1'b0, 6'd2,  16'h0000, 4'd1}, {1'b0, 6'd3,  16'h0000, 4'd1},
    {1'b0, 6'd4,  16'h0000, 4'd2}, {1'b0, 6'd8,  16'h0000, 4'd5},
    {1'b1, 6'd12, 16'hB00C, 4'd5}, {1'b0, 6'd12, 16'h0000, 4'd5},
    {1'b0, 6'd1,  16'h0000, 4'd1}, {1'b1, 6'd63, 16'hB03F, 4'd1},
    {1'b0, 6'd63, 16'h0000, 4'd5}, {1'b0, 6'd62, 16'h0000, 4'd1},
    {1'b0, 6'd3,  16'h0000, 4'd4}, {1'b0, 6'd2,  16'h0000, 4'd1},
    {1'b0, 6'd1,  16'h0000, 4'd1}, {1'b0, 6'd0,  16'h0000, 4'd1}
  };

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int prev, fc, f0;
    bit seen;
    for (int i = 0; i < 64; i++) shadow[i] = init_val(i);
    rst = 1'b1; req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0; rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && bank_start == 4'b0, "R9 in reset",
        int'({req_ready, rsp_valid, bank_start}), int'({1'b1, 1'b0, 4'b0}));
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !rsp_valid && bank_start == 4'b0, "R9 after reset",
        int'({req_ready, rsp_valid, bank_start}), int'({1'b1, 1'b0, 4'b0}));

    // Vector table: timing of acceptance plus data through the monitors.
    prev = 0;
    for (int i = 0; i < 24; i++) begin
      logic [26:0] v;
      v = VEC[i];
      issue(v[26], v[25:20], v[19:4], fc);
      if (v[3:0] != 4'd0) begin
        if (int'(v[3:0]) == CT) chk(fc - prev == CT, "R2 same-bank spacing", fc - prev, CT);
        else chk(fc - prev == int'(v[3:0]), "R3 interleaved spacing", fc - prev, int'(v[3:0]));
      end
      prev = fc;
    end
    repeat (12) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all reads answered", exp_q.size(), 0);

    // R4: a request to a busy bank is held.
    issue(1'b1, 6'd40, 16'hC028, f0);
    req_valid = 1'b1; req_we = 1'b0; req_addr = 6'd44; #1;
    chk(!req_ready, "R4 busy bank stalls", int'(req_ready), 0);
    issue(1'b0, 6'd44, 16'h0000, fc);
    chk(fc - f0 == CT, "R4 released after window", fc - f0, CT);
    repeat (10) @(negedge clk);

    // R6: writes give no response.
    issue(1'b1, 6'd41, 16'hC029, fc);
    seen = 1'b0;
    for (int k = 0; k < 10; k++) begin
      if (rsp_valid) seen = 1'b1;
      @(negedge clk);
    end
    chk(!seen, "R6 write silent", int'(seen), 0);

    // R7/R8: fill the response store with the consumer stalled.
    rsp_ready = 1'b0;
    for (int a = 16; a < 24; a++) issue(1'b0, 6'(a), 16'h0000, fc);
    repeat (10) @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = 6'd24; #1;
    chk(!req_ready, "R7 read blocked when full", int'(req_ready), 0);
    req_we = 1'b1; req_addr = 6'd25; req_wdata = 16'hD019; #1;
    chk(req_ready, "R7 write passes when full", int'(req_ready), 1);
    issue(1'b1, 6'd25, 16'hD019, fc);
    for (int k = 0; k < 3; k++) begin
      chk(rsp_valid && rsp_data == init_val(16), "R8 response held",
          int'(rsp_data), int'(init_val(16)));
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    issue(1'b0, 6'd24, 16'h0000, fc);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R5 drained in order", exp_q.size(), 0);
    chk(st_cyc_q.size() == 0, "R1 every start seen", st_cyc_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule